// File: doc/BRIEF.md
# Checkpoint Two-Phase Quiesce Controller

This controller closes one logging interval of a multiprocessor recorder and opens the next. An interval counter runs from zero; once it reaches a configured length, the controller raises a checkpoint request to all N processor agents. Each agent drains its in-flight work, writes its end-of-interval marker and reports ready, either as a pulse or as a level. The controller remembers every report. When the last agent has reported, it broadcasts the commit. During commit the agents save their architectural state and report done.

On entry to commit, a one-cycle clear pulse resets the per-processor instruction counters, the race-tracking vectors and the per-block "already logged" bits. When every agent has reported done, the commit completes. At that point the interval counter restarts from zero and the log-region pointer steps around a ring of four regions. From the fourth completion onward, the region being entered is the oldest one, and the controller announces that it is reclaimed. This keeps between three and four intervals of history in the ring.

A trigger input stops the processors at any time, including in the middle of a handshake, and abandons any pending checkpoint. The controller then requests a flush of every log buffer and raises a dump-ready flag once all agents have acknowledged. A watchdog sets a sticky error flag when a barrier takes too long.

Top module: `ckpt_quiesce_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is low, `region_ptr` is 0, `reclaim_idx` is 0 and the interval counter is zero.
- R2: The interval counter advances once per cycle from zero. `ckpt_req` rises `INTERVAL`+1 cycles after reset is released, unless a trigger comes first.
- R3: `commit_go` rises only after every agent has shown `agent_ready` high on at least one cycle while `ckpt_req` was high; one-cycle pulses are remembered. `ckpt_req` falls as `commit_go` rises. `commit_go` stays high until every agent has likewise shown `agent_done`.
- R4: `bound_clr` is high for exactly one cycle: the first cycle of `commit_go`.
- R5: When a commit completes, the interval counter restarts from zero. The next `ckpt_req` rises `INTERVAL`+1 cycles after `commit_go` falls.
- R6: Each completed commit advances `region_ptr` by one, wrapping from 3 to 0. Nothing else moves it.
- R7: From the fourth completed commit after reset onward, `reclaim` pulses for one cycle together with the new `region_ptr`, and `reclaim_idx` equals that pointer. `reclaim` stays low on the first three completions.
- R8: A `trigger` seen in the normal states raises `halt` on the next cycle. `flush_req` follows one cycle later. After every agent has shown `flush_ack` while `flush_req` is high, `flush_req` falls, `dump_ready` rises and `halt` stays high.
- R9: A trigger during `ckpt_req` or `commit_go` abandons the checkpoint. No `bound_clr` follows, `region_ptr` does not move, and the flush sequence of R8 starts.
- R10: When one barrier (request plus commit) has lasted `WDOG_LIMIT` cycles, `barrier_err` rises. It stays high until reset.
- R11: Once `halt` is high, `trigger` has no effect. Only reset leaves `dump_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Stop execution and dump the logs |
| agent_ready | input | N_AGENTS | Per-agent ready report (end marker written) |
| agent_done | input | N_AGENTS | Per-agent done report (state saved) |
| flush_ack | input | N_AGENTS | Per-agent log-flush acknowledge |
| ckpt_req | output | 1 | Checkpoint request broadcast |
| commit_go | output | 1 | Commit broadcast |
| bound_clr | output | 1 | One-cycle clear of counters and block bits |
| halt | output | 1 | Processor execution stopped |
| flush_req | output | 1 | Flush all log buffers |
| dump_ready | output | 1 | State is ready to be dumped |
| region_ptr | output | $clog2(N_REGIONS) | Log region currently written |
| reclaim | output | 1 | Oldest region reclaimed this cycle |
| reclaim_idx | output | $clog2(N_REGIONS) | Index of the reclaimed region |
| barrier_err | output | 1 | Sticky barrier-timeout flag |

## Verification
Some properties are local in time, and the assertions check them on every cycle:
- request, commit and halt never overlap;
- a commit is always preceded by a request;
- the clear pulse is a single cycle inside commit;
- a flush happens only under halt;
- dump-ready and the error flag hold once set;
- the region pointer and the reclaim strobe move only on a completed commit.

Other behaviour depends on counts and history, and only the bench's scenarios show it:
- the exact request spacing after reset and after each commit;
- remembered ready pulses arriving at different delays;
- the reclaim starting on the fourth commit;
- triggers landing in the request, the commit and the run state;
- a slow agent tripping the watchdog.

The bench's reference model compares every output on every cycle.

// File: rtl/ckq_pkg.sv
package ckq_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_GATHER = 3'd1,
        ST_COMMIT = 3'd2,
        ST_STOP   = 3'd3,
        ST_FLUSH  = 3'd4,
        ST_DUMP   = 3'd5
    } ctl_state_e;

    typedef struct packed {
        logic req;
        logic go;
        logic halt;
        logic flush;
        logic dump;
    } ctl_out_t;

    function automatic ctl_out_t decode_state(ctl_state_e s);
        ctl_out_t o;
        o.req   = (s == ST_GATHER);
        o.go    = (s == ST_COMMIT);
        o.halt  = (s == ST_STOP) || (s == ST_FLUSH) || (s == ST_DUMP);
        o.flush = (s == ST_FLUSH);
        o.dump  = (s == ST_DUMP);
        return o;
    endfunction

    function automatic logic in_barrier(ctl_state_e s);
        return (s == ST_GATHER) || (s == ST_COMMIT);
    endfunction

    function automatic logic is_halted(ctl_state_e s);
        return (s == ST_STOP) || (s == ST_FLUSH) || (s == ST_DUMP);
    endfunction

endpackage

// File: rtl/ckq_collect.sv
module ckq_collect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic [N-1:0] pulse_in,
    output logic         all_in
);
    logic [N-1:0] seen_q;
    logic [N-1:0] have;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign have[i] = seen_q[i] | pulse_in[i];
        always_ff @(posedge clk) begin
            if (rst || !arm || all_in) begin
                seen_q[i] <= 1'b0;
            end else begin
                seen_q[i] <= have[i];
            end
        end
    end

    assign all_in = arm && (&have);

    // R3: a remembered report only exists inside an armed phase
    a_r3_seen_only_armed: assert property (@(posedge clk) disable iff (rst)
        (!arm) |=> (seen_q == '0));

endmodule

// File: rtl/ckq_interval.sv
module ckq_interval #(
    parameter int INTERVAL   = 333_333_333,
    parameter int WDOG_LIMIT = 10_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic barrier_now,
    input  logic barrier_next,
    output logic expired,
    output logic err
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam int WW = $clog2(WDOG_LIMIT + 1);
    localparam logic [CW-1:0] CNT_END = CW'(INTERVAL);
    localparam logic [WW-1:0] WD_END  = WW'(WDOG_LIMIT);
    localparam logic [WW-1:0] WD_LAST = WW'(WDOG_LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic [WW-1:0] wd_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q < CNT_END) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= CNT_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (barrier_now && (wd_q == WD_LAST)) begin
                err_q <= 1'b1;
            end
            if (barrier_now && barrier_next) begin
                if (wd_q < WD_END) begin
                    wd_q <= wd_q + 1'b1;
                end
            end else begin
                wd_q <= '0;
            end
        end
    end

    assign err = err_q;

    // R10: the error flag never clears without reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R5: after a restart the interval has not expired
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expired);

endmodule

// File: rtl/ckq_ring.sv
module ckq_ring #(
    parameter int N_REGIONS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         advance,
    output logic [$clog2(N_REGIONS)-1:0] ptr,
    output logic                         reclaim,
    output logic [$clog2(N_REGIONS)-1:0] reclaim_idx
);
    localparam int PW = $clog2(N_REGIONS);
    localparam int FW = $clog2(N_REGIONS + 1);
    localparam logic [PW-1:0] PTR_LAST  = PW'(N_REGIONS - 1);
    localparam logic [FW-1:0] FILL_FULL = FW'(N_REGIONS);
    localparam logic [FW-1:0] FILL_OLD  = FW'(N_REGIONS - 1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_nxt;
    logic [FW-1:0] fill_q;
    logic          reclaim_q;
    logic [PW-1:0] idx_q;

    always_comb begin
        ptr_nxt = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            fill_q    <= '0;
            reclaim_q <= 1'b0;
            idx_q     <= '0;
        end else begin
            reclaim_q <= 1'b0;
            if (advance) begin
                ptr_q     <= ptr_nxt;
                idx_q     <= ptr_nxt;
                reclaim_q <= (fill_q >= FILL_OLD);
                if (fill_q < FILL_FULL) begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    assign ptr         = ptr_q;
    assign reclaim     = reclaim_q;
    assign reclaim_idx = idx_q;

    // R6: the pointer moves only on a completed commit
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr_q));

    // R7: a reclaim strobe always follows a commit completion
    a_r7_reclaim_on_advance: assert property (@(posedge clk) disable iff (rst)
        reclaim_q |-> $past(advance));

    // R7: reclaimed region is the one now being written
    a_r7_reclaim_idx: assert property (@(posedge clk) disable iff (rst)
        reclaim_q |-> (idx_q == ptr_q));

endmodule

// File: rtl/ckpt_quiesce_ctrl.sv
module ckpt_quiesce_ctrl
    import ckq_pkg::*;
#(
    parameter int N_AGENTS   = 4,
    parameter int INTERVAL   = 333_333_333,
    parameter int WDOG_LIMIT = 10_000,
    parameter int N_REGIONS  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         trigger,
    input  logic [N_AGENTS-1:0]          agent_ready,
    input  logic [N_AGENTS-1:0]          agent_done,
    input  logic [N_AGENTS-1:0]          flush_ack,
    output logic                         ckpt_req,
    output logic                         commit_go,
    output logic                         bound_clr,
    output logic                         halt,
    output logic                         flush_req,
    output logic                         dump_ready,
    output logic [$clog2(N_REGIONS)-1:0] region_ptr,
    output logic                         reclaim,
    output logic [$clog2(N_REGIONS)-1:0] reclaim_idx,
    output logic                         barrier_err
);
    ctl_state_e state_q;
    ctl_state_e state_nxt;
    ctl_out_t   outs;
    logic       all_ready;
    logic       all_done;
    logic       all_flushed;
    logic       expired;
    logic       commit_end;
    logic       clr_q;

    ckq_collect #(.N(N_AGENTS)) u_ready (
        .clk      (clk),
        .rst      (rst),
        .arm      (state_q == ST_GATHER),
        .pulse_in (agent_ready),
        .all_in   (all_ready)
    );

    ckq_collect #(.N(N_AGENTS)) u_done (
        .clk      (clk),
        .rst      (rst),
        .arm      (state_q == ST_COMMIT),
        .pulse_in (agent_done),
        .all_in   (all_done)
    );

    ckq_collect #(.N(N_AGENTS)) u_flush (
        .clk      (clk),
        .rst      (rst),
        .arm      (state_q == ST_FLUSH),
        .pulse_in (flush_ack),
        .all_in   (all_flushed)
    );

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (trigger)      state_nxt = ST_STOP;
                else if (expired) state_nxt = ST_GATHER;
            end
            ST_GATHER: begin
                if (trigger)        state_nxt = ST_STOP;
                else if (all_ready) state_nxt = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (trigger)       state_nxt = ST_STOP;
                else if (all_done) state_nxt = ST_RUN;
            end
            ST_STOP:  state_nxt = ST_FLUSH;
            ST_FLUSH: begin
                if (all_flushed) state_nxt = ST_DUMP;
            end
            ST_DUMP:  state_nxt = ST_DUMP;
            default:  state_nxt = ST_RUN;
        endcase
    end

    assign commit_end = (state_q == ST_COMMIT) && (state_nxt == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            clr_q   <= (state_q == ST_GATHER) && (state_nxt == ST_COMMIT);
        end
    end

    ckq_interval #(.INTERVAL(INTERVAL), .WDOG_LIMIT(WDOG_LIMIT)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .restart      (commit_end),
        .barrier_now  (in_barrier(state_q)),
        .barrier_next (in_barrier(state_nxt)),
        .expired      (expired),
        .err          (barrier_err)
    );

    ckq_ring #(.N_REGIONS(N_REGIONS)) u_ring (
        .clk         (clk),
        .rst         (rst),
        .advance     (commit_end),
        .ptr         (region_ptr),
        .reclaim     (reclaim),
        .reclaim_idx (reclaim_idx)
    );

    assign outs       = decode_state(state_q);
    assign ckpt_req   = outs.req;
    assign commit_go  = outs.go;
    assign halt       = outs.halt;
    assign flush_req  = outs.flush;
    assign dump_ready = outs.dump;
    assign bound_clr  = clr_q;

    // R1: request, commit and halt are mutually exclusive
    a_r1_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ckpt_req, commit_go, halt}));

    // R2: a request only starts once the interval has run out
    a_r2_req_after_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(ckpt_req) |-> $past(expired));

    // R3: commit is always entered from the request phase
    a_r3_commit_after_req: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_go) |-> $past(ckpt_req));

    // R4: clear pulse lies inside commit and lasts one cycle
    a_r4_clr_in_commit: assert property (@(posedge clk) disable iff (rst)
        bound_clr |-> commit_go);
    a_r4_clr_single: assert property (@(posedge clk) disable iff (rst)
        bound_clr |=> !bound_clr);

    // R8: flushing happens only with execution stopped
    a_r8_flush_halted: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> halt);

    // R11: once halted, nothing but reset resumes execution
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);
    a_r11_dump_holds: assert property (@(posedge clk) disable iff (rst)
        dump_ready |=> dump_ready);

endmodule

// File: tb/tb_ckpt_quiesce_ctrl.sv
module tb_ckpt_quiesce_ctrl;
    localparam int N   = 3;
    localparam int IVL = 20;
    localparam int WD  = 30;
    localparam int NR  = 4;
    localparam int PW  = $clog2(NR);

    // model state codes (behavioural)
    localparam int M_RUN = 0, M_GAT = 1, M_COM = 2, M_STP = 3, M_FLS = 4, M_DMP = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trigger = 1'b0;
    logic [N-1:0] agent_ready = '0;
    logic [N-1:0] agent_done  = '0;
    logic [N-1:0] flush_ack   = '0;
    logic ckpt_req, commit_go, bound_clr, halt, flush_req, dump_ready, reclaim, barrier_err;
    logic [PW-1:0] region_ptr, reclaim_idx;

    always #5 clk = ~clk;

    ckpt_quiesce_ctrl #(.N_AGENTS(N), .INTERVAL(IVL), .WDOG_LIMIT(WD), .N_REGIONS(NR)) dut (
        .clk(clk), .rst(rst), .trigger(trigger),
        .agent_ready(agent_ready), .agent_done(agent_done), .flush_ack(flush_ack),
        .ckpt_req(ckpt_req), .commit_go(commit_go), .bound_clr(bound_clr),
        .halt(halt), .flush_req(flush_req), .dump_ready(dump_ready),
        .region_ptr(region_ptr), .reclaim(reclaim), .reclaim_idx(reclaim_idx),
        .barrier_err(barrier_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int ms, mcnt, mwd, mreg, mfill, midx;
    bit merr, mclr, mrec;
    bit [N-1:0] sr, sd, sf;

    always @(posedge clk) begin
        int nx;
        bit ar, ad, af;
        if (rst) begin
            ms = M_RUN; mcnt = 0; mwd = 0; mreg = 0; mfill = 0; midx = 0;
            merr = 0; mclr = 0; mrec = 0; sr = '0; sd = '0; sf = '0;
        end else begin
            ar = ((sr | agent_ready) == {N{1'b1}});
            ad = ((sd | agent_done)  == {N{1'b1}});
            af = ((sf | flush_ack)   == {N{1'b1}});
            nx = ms;
            case (ms)
                M_RUN: if (trigger) nx = M_STP; else if (mcnt >= IVL) nx = M_GAT;
                M_GAT: if (trigger) nx = M_STP; else if (ar) nx = M_COM;
                M_COM: if (trigger) nx = M_STP; else if (ad) nx = M_RUN;
                M_STP: nx = M_FLS;
                M_FLS: if (af) nx = M_DMP;
                default: nx = M_DMP;
            endcase
            mclr = (ms == M_GAT && nx == M_COM);
            mrec = 0;
            if (ms == M_COM && nx == M_RUN) begin
                mreg = (mreg + 1) % NR;
                midx = mreg;
                mrec = (mfill >= NR - 1);
                if (mfill < NR) mfill++;
                mcnt = 0;
            end else if (mcnt < IVL) begin
                mcnt++;
            end
            if (ms == M_GAT || ms == M_COM) begin
                if (mwd == WD - 1) merr = 1;
                if (nx == M_GAT || nx == M_COM) begin
                    if (mwd < WD) mwd++;
                end else mwd = 0;
            end else mwd = 0;
            sr = (ms == M_GAT && nx == M_GAT) ? (sr | agent_ready) : '0;
            sd = (ms == M_COM && nx == M_COM) ? (sd | agent_done)  : '0;
            sf = (ms == M_FLS && nx == M_FLS) ? (sf | flush_ack)   : '0;
            ms = nx;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk(ckpt_req   == (ms == M_GAT), "R2 ckpt_req", ckpt_req, ms == M_GAT);
            chk(commit_go  == (ms == M_COM), "R3 commit_go", commit_go, ms == M_COM);
            chk(bound_clr  == mclr, "R4 bound_clr", bound_clr, mclr);
            chk(halt == (ms >= M_STP), "R8 halt", halt, ms >= M_STP);
            chk(flush_req  == (ms == M_FLS), "R8 flush_req", flush_req, ms == M_FLS);
            chk(dump_ready == (ms == M_DMP), "R8 dump_ready", dump_ready, ms == M_DMP);
            chk(int'(region_ptr) == mreg, "R6 region_ptr", region_ptr, mreg);
            chk(reclaim == mrec, "R7 reclaim", reclaim, mrec);
            chk(int'(reclaim_idx) == midx, "R7 reclaim_idx", reclaim_idx, midx);
            chk(barrier_err == merr, "R10 barrier_err", barrier_err, merr);
        end
    end

    // ---------------- agents and event monitor ----------------
    int rd[N], dd[N], fd[N];
    int rc[N], dc[N], fc[N];
    int n_commit, n_clr, n_reclaim, gap;
    bit prev_go, prev_req, gap_on;

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (ckpt_req) begin agent_ready[i] <= (rc[i] == rd[i]); rc[i]++; end
            else begin agent_ready[i] <= 1'b0; rc[i] = 0; end
            if (commit_go) begin agent_done[i] <= (dc[i] == dd[i]); dc[i]++; end
            else begin agent_done[i] <= 1'b0; dc[i] = 0; end
            if (flush_req) begin flush_ack[i] <= (fc[i] == fd[i]); fc[i]++; end
            else begin flush_ack[i] <= 1'b0; fc[i] = 0; end
        end
        if (!rst) begin
            if (prev_go && !commit_go && !halt) n_commit++;
            if (bound_clr) n_clr++;
            if (reclaim) n_reclaim++;
            if (prev_go && !commit_go && !halt) begin gap = 0; gap_on = 1; end
            else gap++;
            if (!prev_req && ckpt_req && gap_on) begin
                chk(gap == IVL + 1, "R5 request spacing", gap, IVL + 1);
                gap_on = 0;
            end
        end
        prev_go  = commit_go;
        prev_req = ckpt_req;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trigger = 1'b0;
        repeat (3) @(negedge clk);
        n_commit = 0; n_clr = 0; n_reclaim = 0; gap_on = 0; gap = 0;
        rst = 1'b0;
    endtask

    task automatic wait_commits(input int k);
        while (n_commit < k) @(negedge clk);
    endtask

    task automatic pulse_trigger();
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int reg_before;
        foreach (rd[i]) begin rd[i] = i * 3; dd[i] = 2 - i; fd[i] = i; end
        rd[2] = 7; dd[2] = 5;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!ckpt_req && !commit_go && !bound_clr && !halt && !flush_req && !dump_ready,
            "R1 outputs low in reset", 1, 0);
        chk(region_ptr == 0 && reclaim_idx == 0 && !reclaim && !barrier_err,
            "R1 ring and flags in reset", region_ptr, 0);
        do_reset();
        @(negedge clk);
        chk(!ckpt_req && !halt && region_ptr == 0, "R1 first cycle after reset", ckpt_req, 0);

        // Scenario A: six checkpoints with mixed delays
        wait_commits(6);
        chk(int'(region_ptr) == 2, "R6 pointer after six commits", region_ptr, 2);
        chk(n_reclaim == 3, "R7 reclaims on commits four to six", n_reclaim, 3);
        chk(n_clr == 6, "R4 one clear per commit", n_clr, 6);
        chk(!barrier_err, "R10 no error on quick barriers", barrier_err, 0);

        // trigger inside commit: abort (R9) then flush (R8)
        while (!commit_go) @(negedge clk);
        reg_before = region_ptr;
        pulse_trigger();
        chk(halt && !commit_go, "R8 halt after trigger", halt, 1);
        @(negedge clk);
        chk(flush_req, "R8 flush follows halt", flush_req, 1);
        while (!dump_ready) @(negedge clk);
        chk(int'(region_ptr) == reg_before, "R9 commit abort keeps region", region_ptr, reg_before);
        chk(n_commit == 6, "R9 aborted commit not completed", n_commit, 6);
        pulse_trigger();
        repeat (4) @(negedge clk);
        chk(dump_ready && halt && !flush_req, "R11 trigger ignored when dumped", dump_ready, 1);

        // Scenario B: trigger inside request phase
        rd[1] = 12;
        do_reset();
        while (!ckpt_req) @(negedge clk);
        repeat (3) @(negedge clk);
        pulse_trigger();
        while (!dump_ready) @(negedge clk);
        chk(n_clr == 0, "R9 request abort gives no clear", n_clr, 0);
        chk(region_ptr == 0, "R9 request abort keeps region", region_ptr, 0);

        // Scenario C: slow agent trips the watchdog
        rd[1] = 3; rd[2] = 45;
        do_reset();
        wait_commits(2);
        chk(barrier_err, "R10 error after slow barrier", barrier_err, 1);
        rd[2] = 1;
        wait_commits(3);
        chk(barrier_err, "R10 error stays set", barrier_err, 1);
        while (ckpt_req || commit_go) @(negedge clk);
        pulse_trigger();
        while (!dump_ready) @(negedge clk);
        chk(int'(region_ptr) == 3, "R8 dump from run state keeps region", region_ptr, 3);

        repeat (3) @(negedge clk);
        report();
    end

endmodule